// File: doc/BRIEF.md
# Periodic Tick Interrupt Timer

This block produces a periodic interrupt for a real-time-clock subsystem. A free-running prescaler counts pulses of a 32.768 kHz reference enable. A four-bit rate select picks a power-of-two division of that reference, so each tick comes once every 2^N reference pulses. A down counter moves one step per tick. When it runs out, the counter reloads from a programmable period register and latches an interrupt-pending flag. That flag drives a level interrupt until software clears it.

Software reaches the block through a single-cycle write port with three register slots. Slot 0 is control: bit 0 is the master enable, bits [7:4] are the rate select N and bit 8 is the timer enable. Slot 1 is the period. Slot 2 is pending, where bit 0 is the tick flag. Slot 3 is unused. The live counter value is always visible on a dedicated output.

Top module: `rtc_tick_timer`

## Requirements
- R1: With rate select N taken from control bits [7:4], the counter advances once every 2^N reference pulses. The first advance after reset falls on reference pulse number 2^N.
- R2: A write to the period slot (address 1) is stored only when the written value is greater than 2. Any smaller value leaves the previous period in place.
- R3: A control write (address 0) that sets master enable (bit 0) and changes timer enable (bit 8) from 0 to 1, while the stored period is nonzero, loads the period into the counter on the next cycle and starts it.
- R4: A control write does not start the counter in three cases: master enable is 0, the stored period is 0, or timer enable was already 1.
- R5: A control write that keeps master enable at 1 and clears timer enable stops the counter. The counter holds its value while stopped.
- R6: A control write that clears master enable stops the counter, whatever value timer enable takes. Re-setting master enable alone does not restart the counter.
- R7: While running, each tick decrements the counter. A tick that finds the counter at 1 or below reloads the stored period, sets the pending flag and raises the interrupt, and the counter keeps running. The interrupt period is therefore the stored period in ticks.
- R8: Writing 1 to bit 0 of the pending slot (address 2) clears the flag and drops the interrupt. Writing 0 there changes nothing. If an expiry falls in the same cycle as a clear, the flag stays set.
- R9: After reset the counter reads 0 and is stopped, the interrupt is low, and the period, control and prescaler are all zero.
- R10: A write to address 3 has no effect on the counter or on the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_pulse_i | input | 1 | One-cycle enable per 32.768 kHz reference period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register slot: 0 control, 1 period, 2 pending, 3 unused |
| wr_data_i | input | DATA_W (32) | Write data |
| cur_count_o | output | CNT_W (32) | Live counter value |
| tick_irq_o | output | 1 | Level interrupt, high while the pending flag is set |

## Verification
The bench attacks the start condition from every side. It sets master enable and timer enable in the wrong order, rewrites a timer enable that is already set, and tries to start with an empty period register. A design that starts on the level of the enable bit instead of its edge would count in each of these cases. Period writes of 0, 1 and 2 are mixed with accepted values, which catches a floor compare that is off by one or a rejected write that clears the old value. The bench also lines up an expiry with a pending clear in the same cycle, where a design with the wrong priority loses the interrupt. Prescaler phase after reset is checked at a non-zero rate select, where an off-by-one mask ticks one reference pulse early.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

   typedef enum logic [1:0] {
      SLOT_CTRL   = 2'd0,
      SLOT_PERIOD = 2'd1,
      SLOT_PEND   = 2'd2,
      SLOT_SPARE  = 2'd3
   } slot_e;

   // control field positions (software visible)
   localparam int unsigned MEN_BIT  = 0;
   localparam int unsigned RATE_LSB = 4;
   localparam int unsigned TEN_BIT  = 8;

   // pending slot field position
   localparam int unsigned PEND_BIT = 0;

endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler #(
   parameter int unsigned SEL_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ref_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);

   localparam int unsigned PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   // bit b of the mask is set when the select asks for more than b stages
   for (genvar b = 0; b < PRE_W; b++) begin : g_mask
      assign mask[b] = (sel_i > SEL_W'(b));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pre_q <= '0;
      else if (ref_i) pre_q <= pre_q + 1'b1;
   end

   assign tick_o = ref_i && ((pre_q & mask) == mask);

   // R1: right after a tick, the selected low prescaler bits have wrapped to zero
   a_r1_tick_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> ((pre_q & $past(mask)) == '0));

endmodule

// File: rtl/rtc_tick_regs.sv
module rtc_tick_regs
   import rtc_tick_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned SEL_W     = 4,
   parameter int unsigned CNT_FLOOR = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              men_o,
   output logic              ten_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic [CNT_W-1:0]  period_o,
   output logic              start_o,
   output logic              stop_o,
   output logic              clr_o
);

   logic              men_q, ten_q;
   logic [SEL_W-1:0]  sel_q;
   logic [CNT_W-1:0]  period_q;
   logic              wr_ctrl, wr_period, wr_pend;
   logic              d_men, d_ten, period_ok;

   assign wr_ctrl   = wr_en_i && (slot_e'(wr_addr_i) == SLOT_CTRL);
   assign wr_period = wr_en_i && (slot_e'(wr_addr_i) == SLOT_PERIOD);
   assign wr_pend   = wr_en_i && (slot_e'(wr_addr_i) == SLOT_PEND);

   assign d_men     = wr_data_i[MEN_BIT];
   assign d_ten     = wr_data_i[TEN_BIT];
   assign period_ok = (wr_data_i > DATA_W'(CNT_FLOOR));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         men_q <= 1'b0;
         ten_q <= 1'b0;
         sel_q <= '0;
      end else if (wr_ctrl) begin
         men_q <= d_men;
         ten_q <= d_ten;
         sel_q <= wr_data_i[RATE_LSB +: SEL_W];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     period_q <= '0;
      else if (wr_period && period_ok) period_q <= wr_data_i[CNT_W-1:0];
   end

   // start only on a rising timer enable under master enable with a period on hand
   assign start_o = wr_ctrl && d_men && d_ten && !ten_q && (period_q != '0);
   // stop on a falling master enable, or on a falling timer enable under master enable
   assign stop_o  = wr_ctrl && ((!d_men && men_q) || (d_men && !d_ten && ten_q));
   assign clr_o   = wr_pend && wr_data_i[PEND_BIT];

   assign men_o    = men_q;
   assign ten_o    = ten_q;
   assign sel_o    = sel_q;
   assign period_o = period_q;

   // R2: a period write at or below the floor leaves the stored period untouched
   a_r2_floor_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == 2'd1 && wr_data_i <= DATA_W'(CNT_FLOOR)) |=> $stable(period_q));

   // R2: a period write above the floor is taken
   a_r2_floor_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == 2'd1 && wr_data_i > DATA_W'(CNT_FLOOR))
         |=> (period_q == $past(wr_data_i[CNT_W-1:0])));

endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             run_o,
   output logic             pend_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q, pend_q;
   logic             expire;

   assign expire = run_q && tick_i && !stop_i && !start_i && (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (stop_i) begin
         run_q <= 1'b0;
      end else if (start_i) begin
         run_q <= 1'b1;
         cnt_q <= period_i;
      end else if (run_q && tick_i) begin
         if (cnt_q <= CNT_W'(1)) cnt_q <= period_i;
         else                    cnt_q <= cnt_q - 1'b1;
      end
   end

   // an expiry outranks a clear landing in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_q <= 1'b0;
      else if (expire) pend_q <= 1'b1;
      else if (clr_i)  pend_q <= 1'b0;
   end

   assign cnt_o  = cnt_q;
   assign run_o  = run_q;
   assign pend_o = pend_q;

   // R3: a start loads the period and runs
   a_r3_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (run_q && cnt_q == $past(period_i)));

   // R5: a stop halts the counter and freezes its value
   a_r5_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (!run_q && cnt_q == $past(cnt_q)));

   // R7: running out reloads and flags
   a_r7_expire_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && tick_i && !stop_i && !start_i && cnt_q <= CNT_W'(1))
         |=> (pend_q && run_q && cnt_q == $past(period_i)));

   // R8: a clear with no expiry drops the flag
   a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !(run_q && tick_i && !stop_i && cnt_q <= CNT_W'(1))) |=> !pend_q);

   // R8: without a clear the flag stays set
   a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q && !clr_i) |=> pend_q);

endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
   import rtc_tick_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned SEL_W     = 4,
   parameter int unsigned CNT_FLOOR = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ref_pulse_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [CNT_W-1:0]  cur_count_o,
   output logic              tick_irq_o
);

   localparam int unsigned CTRL_MSB = (TEN_BIT > RATE_LSB + SEL_W - 1) ? TEN_BIT
                                                                       : RATE_LSB + SEL_W - 1;

   if (DATA_W <= CTRL_MSB) begin : g_bad_data_w
      $error("rtc_tick_timer: DATA_W too narrow for the control fields");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("rtc_tick_timer: CNT_W must not exceed DATA_W");
   end
   if (CNT_W < 2 || (CNT_FLOOR + 1) >= (64'd1 << CNT_W)) begin : g_bad_floor
      $error("rtc_tick_timer: CNT_W cannot hold a period above CNT_FLOOR");
   end
   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel_w
      $error("rtc_tick_timer: SEL_W must be 1 to 5");
   end

   logic             men, ten, tick, start, stop, clr, run, pend;
   logic [SEL_W-1:0] sel;
   logic [CNT_W-1:0] period, cnt;

   rtc_tick_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ref_i  (ref_pulse_i),
      .sel_i  (sel),
      .tick_o (tick)
   );

   rtc_tick_regs #(
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .SEL_W     (SEL_W),
      .CNT_FLOOR (CNT_FLOOR)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .men_o     (men),
      .ten_o     (ten),
      .sel_o     (sel),
      .period_o  (period),
      .start_o   (start),
      .stop_o    (stop),
      .clr_o     (clr)
   );

   rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .start_i  (start),
      .stop_i   (stop),
      .clr_i    (clr),
      .period_i (period),
      .cnt_o    (cnt),
      .run_o    (run),
      .pend_o   (pend)
   );

   assign cur_count_o = cnt;
   assign tick_irq_o  = pend;

   // R6: the counter never runs unless both enables are held in control
   a_r6_run_needs_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run |-> (men && ten));

   // R10: a write to the spare slot leaves count and interrupt alone (no tick)
   a_r10_spare_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == 2'd3 && !ref_pulse_i) |=> ($stable(cnt) && $stable(pend)));

endmodule

// File: tb/rtc_tick_timer_tb.sv
module rtc_tick_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_p = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] cnt;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   rtc_tick_timer u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ref_pulse_i (ref_p),
      .wr_en_i     (wr_en),
      .wr_addr_i   (wr_addr),
      .wr_data_i   (wr_data),
      .cur_count_o (cnt),
      .tick_irq_o  (irq)
   );

   typedef struct packed {
      logic [31:0] first;
      logic [31:0] second;
      logic [31:0] expect_cnt;
   } vec_t;

   // R2 vectors: two period writes, then a start; the counter shows the stored period
   localparam vec_t VEC [7] = '{
      '{32'd10,         32'd2,   32'd10},
      '{32'd10,         32'd3,   32'd3},
      '{32'd0,          32'd1,   32'd0},
      '{32'd2,          32'd2,   32'd0},
      '{32'd4,          32'd0,   32'd4},
      '{32'hFFFF_FFFF,  32'd1,   32'hFFFF_FFFF},
      '{32'd3,          32'd100, 32'd100}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      ref_p = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic refp(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ref_p = 1'b1;
         @(negedge clk);
         ref_p = 1'b0;
      end
   endtask

   initial begin
      do_reset();
      // R9: reset state
      check("R9 count after reset", cnt, 32'd0);
      check("R9 irq after reset", {31'd0, irq}, 32'd0);
      refp(3);
      check("R9 stopped after reset", cnt, 32'd0);

      // R2: table of period writes
      for (int v = 0; v < 7; v++) begin
         do_reset();
         wr(2'd1, VEC[v].first);
         wr(2'd1, VEC[v].second);
         wr(2'd0, 32'h101);
         check($sformatf("R2 vector %0d", v), cnt, VEC[v].expect_cnt);
      end

      // R3, R7: period 3 at rate 0
      do_reset();
      wr(2'd1, 32'd3);
      wr(2'd0, 32'h101);
      check("R3 start loads period", cnt, 32'd3);
      refp(1); check("R7 first decrement", cnt, 32'd2);
      refp(1); check("R7 second decrement", cnt, 32'd1);
      check("R7 no irq before expiry", {31'd0, irq}, 32'd0);
      refp(1); check("R7 reload on expiry", cnt, 32'd3);
      check("R7 irq on expiry", {31'd0, irq}, 32'd1);
      refp(1); check("R7 keeps running", cnt, 32'd2);

      // R8: write 0 keeps the flag, write 1 clears it
      wr(2'd2, 32'h0);
      check("R8 write 0 no effect", {31'd0, irq}, 32'd1);
      // R10: spare slot write
      wr(2'd3, 32'hFFFF_FFFF);
      check("R10 spare keeps irq", {31'd0, irq}, 32'd1);
      check("R10 spare keeps count", cnt, 32'd2);
      wr(2'd2, 32'h1);
      check("R8 write 1 clears", {31'd0, irq}, 32'd0);

      // R1: rate select 2, first advance on reference pulse 4
      do_reset();
      wr(2'd1, 32'd4);
      wr(2'd0, 32'h121);
      refp(3);
      check("R1 no advance before pulse 4", cnt, 32'd4);
      refp(1);
      check("R1 advance on pulse 4", cnt, 32'd3);
      refp(3);
      check("R1 no advance pulses 5-7", cnt, 32'd3);
      refp(1);
      check("R1 advance on pulse 8", cnt, 32'd2);

      // R5: clear timer enable under master enable; prescaler now at 8, tick at 12
      wr(2'd0, 32'h021);
      refp(8);
      check("R5 counter held", cnt, 32'd2);
      // R3: new rising edge reloads
      wr(2'd0, 32'h121);
      check("R3 restart reloads", cnt, 32'd4);

      // R6: master clear stops, master alone does not restart
      wr(2'd0, 32'h120);
      refp(8);
      check("R6 stopped by master clear", cnt, 32'd4);
      wr(2'd0, 32'h121);
      refp(8);
      check("R6 master alone no restart", cnt, 32'd4);
      wr(2'd0, 32'h021);
      wr(2'd0, 32'h121);
      refp(4);
      check("R6 fresh edge restarts", cnt, 32'd3);

      // R4: no start without master, or on a level enable
      do_reset();
      wr(2'd1, 32'd5);
      wr(2'd0, 32'h100);
      refp(2);
      check("R4 no start without master", cnt, 32'd0);
      wr(2'd0, 32'h101);
      refp(2);
      check("R4 no start on level enable", cnt, 32'd0);
      // R4: empty period
      do_reset();
      wr(2'd0, 32'h101);
      refp(2);
      check("R4 no start with zero period", cnt, 32'd0);
      check("R4 no irq with zero period", {31'd0, irq}, 32'd0);

      // R8: expiry and clear in the same cycle
      do_reset();
      wr(2'd1, 32'd3);
      wr(2'd0, 32'h101);
      refp(3);
      check("R8 setup irq", {31'd0, irq}, 32'd1);
      refp(2);
      check("R8 setup count", cnt, 32'd1);
      @(negedge clk);
      ref_p = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h1;
      @(negedge clk);
      ref_p = 1'b0; wr_en = 1'b0;
      check("R8 expiry wins over clear", {31'd0, irq}, 32'd1);
      check("R8 reload during clear", cnt, 32'd3);
      wr(2'd2, 32'h1);
      check("R8 later clear", {31'd0, irq}, 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule